// File: doc/BRIEF.md
# Cartridge SRAM Bank Mapper

This block places windows of a 2 MB cartridge SRAM into the expansion regions of an 8-bit host. The host has seven mapped regions:

- three contiguous 8 KB block regions at $2000, $4000 and $6000;
- one separate 8 KB auto-start region at $A000;
- three 1 KB low RAM regions at $0400, $0800 and $0C00.

Each region has its own one-byte bank number. That byte picks one of 256 8 KB chunks of the SRAM, so one register write swaps a whole window at once. A low RAM region shows the bytes at chunk offsets $0400..$0FFF of its chunk, in the same place they would sit in a full 8 KB view.

The host reaches the bank numbers and a region-enable byte through a small register window. Software can read these registers back. The mapper decodes every host cycle combinationally and drives:

- the 21-bit SRAM address;
- the chip enable and write enable;
- the read-back data of its own registers.

A hard reset clears the mapping. The soft-reset input changes nothing, so soft-loaded content in the auto-start region stays mapped across a warm restart. Neither kind of reset writes to the SRAM.

Top module: `bank_mapper`

## Requirements
- R1: A hard reset (rst high at a clock edge) sets every bank register and the enable byte to zero, and all of them read back as zero.
- R2: The register window is 8 bytes at REG_BASE ($9C00). Offset 0 holds the enable byte, where bit i enables region i. Offsets 1..7 hold the bank numbers of regions 0..6. The region order is $0400, $0800, $0C00, $2000, $4000, $6000, $A000. A write takes effect at the clock edge that ends the cycle. A read of the window drives rdata_oe with the stored byte; enable bit 7 reads as 0.
- R3: An access to an enabled 8 KB region (block or auto-start) asserts sram_ce with sram_addr = {bank, host_addr[12:0]}.
- R4: An access to an enabled low RAM region asserts sram_ce with sram_addr = {that region's own bank, host_addr[12:0]}. The low 13 bits therefore lie in $0400..$0FFF.
- R5: An access to a region whose enable bit is 0 asserts neither sram_ce nor rdata_oe.
- R6: Holding soft_rst high changes no register. Both read-back and translation stay the same.
- R7: An address outside every region and outside the register window asserts neither sram_ce nor rdata_oe. No access of any kind happens while bus_valid is low.
- R8: sram_we is high only together with sram_ce on a host write. An access to the register window never asserts sram_ce.
- R9: A bank write is used whole on the very next cycle. An access right after the write translates with the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hard reset, synchronous, active high |
| soft_rst | input | 1 | Warm restart indication; leaves the mapping alone |
| bus_valid | input | 1 | Host cycle in progress |
| bus_we | input | 1 | Host cycle is a write |
| bus_addr | input | 16 | Host address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Register read-back data |
| bus_rdata_oe | output | 1 | Mapper drives the host data bus |
| sram_addr | output | 21 | SRAM byte address |
| sram_ce | output | 1 | SRAM chip enable |
| sram_we | output | 1 | SRAM write enable |

## Verification
Translation is tried on every region with a distinct bank byte, so an address built from the wrong region's register shows up at once. It is also tried at the first and last byte of the 8 KB windows and at both ends of the $0400..$0FFF low area, which exposes offset truncation and bounds errors.

Addresses just outside each region, and the bytes around the register window, separate correct decoding from decoding that is too broad. Clearing single enable bits shows that a disabled region stays off the bus while its neighbours keep working. A bank write followed at once by an access, and a long soft_rst pulse, show that the mapping changes only through writes and hard reset.

// File: rtl/bmap_pkg.sv
package bmap_pkg;

    localparam int NUM_REGION = 7;
    localparam int SEL_W      = 3;

    typedef enum logic [2:0] {
        RG_LOW0  = 3'd0,
        RG_LOW1  = 3'd1,
        RG_LOW2  = 3'd2,
        RG_BLK1  = 3'd3,
        RG_BLK2  = 3'd4,
        RG_BLK3  = 3'd5,
        RG_AUTO  = 3'd6,
        RG_NONE  = 3'd7
    } region_e;

    // Which mapped region a host address falls in, if any.
    function automatic region_e classify(input logic [15:0] a);
        region_e r;
        r = RG_NONE;
        if (a[15:12] == 4'h0) begin
            case (a[11:10])
                2'd1:    r = RG_LOW0;
                2'd2:    r = RG_LOW1;
                2'd3:    r = RG_LOW2;
                default: r = RG_NONE;
            endcase
        end else begin
            case (a[15:13])
                3'd1:    r = RG_BLK1;
                3'd2:    r = RG_BLK2;
                3'd3:    r = RG_BLK3;
                3'd5:    r = RG_AUTO;
                default: r = RG_NONE;
            endcase
        end
        return r;
    endfunction

    typedef struct packed {
        region_e        region;
        logic           live;
        logic           reg_hit;
        logic [SEL_W-1:0] reg_sel;
    } decode_t;

endpackage

// File: rtl/bmap_regfile.sv
module bmap_regfile
    import bmap_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               soft_rst,
    input  logic                               wr_en,
    input  logic [SEL_W-1:0]                   wr_sel,
    input  logic [BANK_W-1:0]                  wr_data,
    input  logic [SEL_W-1:0]                   rd_sel,
    output logic [BANK_W-1:0]                  rd_data,
    output logic [NUM_REGION-1:0][BANK_W-1:0]  bank_q,
    output logic [NUM_REGION-1:0]              enable_q
);

    localparam int PAD_W = BANK_W - NUM_REGION;

    // Enable byte at select 0.
    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
        end else if (wr_en && wr_sel == '0) begin
            enable_q <= wr_data[NUM_REGION-1:0];
        end
    end

    // One bank register per region, at selects 1..7.
    for (genvar g = 0; g < NUM_REGION; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q[g] <= '0;
            end else if (wr_en && wr_sel == SEL_W'(g + 1)) begin
                bank_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        if (rd_sel == '0) begin
            rd_data = {{PAD_W{1'b0}}, enable_q};
        end else begin
            rd_data = bank_q[rd_sel - SEL_W'(1)];
        end
    end

    p_hard_clear_r1: assert property (@(posedge clk)
        rst |=> (bank_q == '0) && (enable_q == '0))
        else $error("hard reset did not clear mapping");

    p_bank_write_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel != '0) |=> bank_q[$past(wr_sel) - SEL_W'(1)] == $past(wr_data))
        else $error("bank byte not taken whole");

    p_soft_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (soft_rst && !wr_en) |=> $stable(bank_q) && $stable(enable_q))
        else $error("soft reset touched a register");

endmodule

// File: rtl/bmap_decoder.sv
module bmap_decoder
    import bmap_pkg::*;
#(
    parameter logic [15:0] REG_BASE = 16'h9C00
) (
    input  logic                  bus_valid,
    input  logic [15:0]           bus_addr,
    input  logic [NUM_REGION-1:0] enable_q,
    output decode_t               dec
);

    region_e          region;
    logic             in_window;
    logic [NUM_REGION-1:0] hit_vec;

    assign region    = classify(bus_addr);
    assign in_window = (bus_addr[15:SEL_W] == REG_BASE[15:SEL_W]);

    for (genvar g = 0; g < NUM_REGION; g++) begin : g_hit
        assign hit_vec[g] = bus_valid && (region == region_e'(g)) && enable_q[g];
    end

    always_comb begin
        dec.region  = region;
        dec.live    = |hit_vec;
        dec.reg_hit = bus_valid && in_window;
        dec.reg_sel = bus_addr[SEL_W-1:0];
    end

endmodule

// File: rtl/bmap_translate.sv
module bmap_translate
    import bmap_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int OFS_W  = 13
) (
    input  region_e                            region,
    input  logic [15:0]                        bus_addr,
    input  logic [NUM_REGION-1:0][BANK_W-1:0]  bank_q,
    output logic [BANK_W+OFS_W-1:0]            sram_addr
);

    logic [BANK_W-1:0] sel_bank;

    always_comb begin
        if (region == RG_NONE) begin
            sel_bank = '0;
        end else begin
            sel_bank = bank_q[region];
        end
    end

    // Low RAM regions keep their host offset, so they land on chunk offsets
    // $0400..$0FFF; 8 KB regions use the full 13-bit offset.
    assign sram_addr = {sel_bank, bus_addr[OFS_W-1:0]};

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bmap_pkg::*;
#(
    parameter int          BANK_W   = 8,
    parameter int          OFS_W    = 13,
    parameter logic [15:0] REG_BASE = 16'h9C00
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     soft_rst,
    input  logic                     bus_valid,
    input  logic                     bus_we,
    input  logic [15:0]              bus_addr,
    input  logic [BANK_W-1:0]        bus_wdata,
    output logic [BANK_W-1:0]        bus_rdata,
    output logic                     bus_rdata_oe,
    output logic [BANK_W+OFS_W-1:0]  sram_addr,
    output logic                     sram_ce,
    output logic                     sram_we
);

    localparam int SRAM_AW = BANK_W + OFS_W;

    decode_t                            dec;
    logic [NUM_REGION-1:0][BANK_W-1:0]  bank_q;
    logic [NUM_REGION-1:0]              enable_q;
    logic [BANK_W-1:0]                  rd_data;
    logic [SRAM_AW-1:0]                 xlat_addr;

    bmap_decoder #(.REG_BASE(REG_BASE)) u_dec (
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .enable_q  (enable_q),
        .dec       (dec)
    );

    bmap_regfile #(.BANK_W(BANK_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .wr_en    (dec.reg_hit && bus_we),
        .wr_sel   (dec.reg_sel),
        .wr_data  (bus_wdata),
        .rd_sel   (dec.reg_sel),
        .rd_data  (rd_data),
        .bank_q   (bank_q),
        .enable_q (enable_q)
    );

    bmap_translate #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_xlat (
        .region    (dec.region),
        .bus_addr  (bus_addr),
        .bank_q    (bank_q),
        .sram_addr (xlat_addr)
    );

    assign sram_ce      = dec.live;
    assign sram_we      = dec.live && bus_we;
    assign sram_addr    = xlat_addr;
    assign bus_rdata_oe = dec.reg_hit && !bus_we;
    assign bus_rdata    = bus_rdata_oe ? rd_data : '0;

    p_ce_enabled_r5: assert property (@(posedge clk) disable iff (rst)
        sram_ce |-> bus_valid && enable_q[dec.region])
        else $error("chip enable for a disabled region");

    p_window_no_ce_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_addr[15:SEL_W] == REG_BASE[15:SEL_W]) |-> !sram_ce)
        else $error("register access reached the SRAM");

    p_we_with_ce_r8: assert property (@(posedge clk) disable iff (rst)
        sram_we |-> sram_ce && bus_we)
        else $error("write strobe without chip enable");

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |-> !sram_ce && !bus_rdata_oe)
        else $error("activity without a host cycle");

endmodule

// File: tb/tb_bank_mapper.sv
module tb_bank_mapper;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rdata_oe;
    logic [20:0] sram_addr;
    logic        sram_ce;
    logic        sram_we;

    int checks = 0;
    int fails  = 0;

    localparam logic [15:0] RB = 16'h9C00;

    bank_mapper dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
        .sram_addr(sram_addr), .sram_ce(sram_ce), .sram_we(sram_we)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    // Present a read on the bus and sample just after the falling edge.
    task automatic rd_reg(input string req, input int ofs, input logic [7:0] exp);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = RB + 16'(ofs);
        #1;
        check(req, "reg oe", 32'(bus_rdata_oe), 32'd1);
        check(req, "reg data", 32'(bus_rdata), 32'(exp));
        check("R8", "reg ce", 32'(sram_ce), 32'd0);
        bus_valid = 1'b0;
    endtask

    task automatic mem(input string req, input logic [15:0] a, input logic we,
                       input logic ce_exp, input logic [20:0] addr_exp);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = we; bus_addr = a;
        #1;
        check(req, "ce", 32'(sram_ce), 32'(ce_exp));
        check(req, "oe", 32'(bus_rdata_oe), 32'd0);
        check("R8", "we", 32'(sram_we), 32'(ce_exp & we));
        if (ce_exp) check(req, "sram addr", 32'(sram_addr), 32'(addr_exp));
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    function automatic logic [7:0] bank_val(input int i);
        return 8'(8'h31 + 8'(i) * 8'h25);
    endfunction

    task automatic t_reset();
        for (int i = 0; i < 8; i++) rd_reg("R1", i, 8'h00);
        mem("R5", 16'h2000, 1'b0, 1'b0, '0);
    endtask

    task automatic t_program();
        for (int i = 0; i < 7; i++) wr(RB + 16'(i + 1), bank_val(i));
        wr(RB, 8'hFF);
        rd_reg("R2", 0, 8'h7F);
        for (int i = 0; i < 7; i++) rd_reg("R2", i + 1, bank_val(i));
    endtask

    task automatic t_blocks();
        mem("R3", 16'h2000, 1'b0, 1'b1, {bank_val(3), 13'h0000});
        mem("R3", 16'h3FFF, 1'b1, 1'b1, {bank_val(3), 13'h1FFF});
        mem("R3", 16'h4123, 1'b0, 1'b1, {bank_val(4), 13'h0123});
        mem("R3", 16'h7FFF, 1'b1, 1'b1, {bank_val(5), 13'h1FFF});
        mem("R3", 16'hA000, 1'b0, 1'b1, {bank_val(6), 13'h0000});
        mem("R3", 16'hBFFE, 1'b1, 1'b1, {bank_val(6), 13'h1FFE});
    endtask

    task automatic t_low();
        mem("R4", 16'h0400, 1'b0, 1'b1, {bank_val(0), 13'h0400});
        mem("R4", 16'h07FF, 1'b1, 1'b1, {bank_val(0), 13'h07FF});
        mem("R4", 16'h0A5A, 1'b0, 1'b1, {bank_val(1), 13'h0A5A});
        mem("R4", 16'h0C00, 1'b1, 1'b1, {bank_val(2), 13'h0C00});
        mem("R4", 16'h0FFF, 1'b0, 1'b1, {bank_val(2), 13'h0FFF});
    endtask

    task automatic t_outside();
        mem("R7", 16'h0000, 1'b0, 1'b0, '0);
        mem("R7", 16'h03FF, 1'b1, 1'b0, '0);
        mem("R7", 16'h1000, 1'b0, 1'b0, '0);
        mem("R7", 16'h8000, 1'b1, 1'b0, '0);
        mem("R7", 16'h9BFF, 1'b0, 1'b0, '0);
        mem("R7", 16'h9C08, 1'b0, 1'b0, '0);
        mem("R7", 16'hC000, 1'b0, 1'b0, '0);
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0; bus_addr = 16'h2000;
        #1;
        check("R7", "idle ce", 32'(sram_ce), 32'd0);
    endtask

    task automatic t_disable();
        wr(RB, 8'h7F & ~8'h08 & ~8'h02);
        mem("R5", 16'h2000, 1'b0, 1'b0, '0);
        mem("R5", 16'h2000, 1'b1, 1'b0, '0);
        mem("R5", 16'h0800, 1'b0, 1'b0, '0);
        mem("R5", 16'h4000, 1'b0, 1'b1, {bank_val(4), 13'h0000});
        mem("R5", 16'h0400, 1'b0, 1'b1, {bank_val(0), 13'h0400});
        wr(RB, 8'h7F);
    endtask

    task automatic t_soft();
        @(negedge clk);
        soft_rst = 1'b1;
        repeat (5) @(negedge clk);
        for (int i = 0; i < 7; i++) rd_reg("R6", i + 1, bank_val(i));
        rd_reg("R6", 0, 8'h7F);
        mem("R6", 16'hA010, 1'b0, 1'b1, {bank_val(6), 13'h0010});
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    task automatic t_atomic();
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = RB + 16'd4; bus_wdata = 8'hC3;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 16'h2345;
        #1;
        check("R9", "new bank", 32'(sram_addr), 32'({8'hC3, 13'h0345}));
        check("R9", "ce", 32'(sram_ce), 32'd1);
        bus_valid = 1'b0;
    endtask

    task automatic t_hard_again();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 8; i++) rd_reg("R1", i, 8'h00);
        mem("R1", 16'hA000, 1'b0, 1'b0, '0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_program();
        t_blocks();
        t_low();
        t_outside();
        t_disable();
        t_soft();
        t_atomic();
        t_hard_again();
        idle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule